// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Countdown Interrupts

This block keeps time as a seconds count plus a milliseconds count, advanced by a slow reference clock of about 32.768 kHz. The slow clock enters as an ordinary input, passes a two-flop synchronizer, and its rising edges drive a fractional divider. The divider adds a fixed increment on every slow edge and emits a millisecond step whenever the sum passes the modulus. The live counters are copied to a bus-side pair of registers once every `COPY_TICKS` slow periods. A busy flag covers the slow period just before each copy and the copy cycle itself.

Software reads the bus-side values through a simple single-cycle register port. A read of the milliseconds register also copies the bus-side seconds into a shadow register in the same access, so a milliseconds read followed by a shadow read gives a coherent pair. Every write is refused while busy is high, and a sticky error flag records the refusal. Three alarm comparators and two countdown timers set bits in a write-one-to-clear event register. A mask register selects which events drive the active-high level interrupt.

Top module: `rtc_counter_top`

## Requirements
- R1: The milliseconds counter steps once for each overflow of the fractional divider, so after n slow edges it has stepped floor(n*FRAC_INC/FRAC_MOD) times. It runs from 0 to MS_WRAP-1, then returns to 0 and adds one to the seconds counter.
- R2: A read of the milliseconds register (offset 0x10) returns the bus-side milliseconds. On the same clock edge it loads the shadow register (offset 0x0C) with the bus-side seconds.
- R3: The bus-side seconds (offset 0x08) and milliseconds take the live values after every COPY_TICKS-th slow edge. Bit 0 of the status word at offset 0x04 reads 1 in the slow period before each copy and in the copy cycle, and 0 at all other times.
- R4: A write of any register while busy is high has no effect and sets the sticky error flag (bit 1 at offset 0x04). Writing 1 to that bit outside the busy window clears the flag.
- R5: A write to offset 0x08 outside the busy window loads both the live and the bus-side seconds, and counting continues from the written value.
- R6: The seconds alarms (0x14, 0x18) and the milliseconds alarm (0x1C) set event bits 0, 1 and 2. A bit is set on the cycle its counter takes a new value equal to the alarm value. An alarm value of 0 never fires.
- R7: The seconds countdown (0x20) and the milliseconds countdown (0x24) load on a write and step down once per seconds rollover or per millisecond step. They set event bit 3 or bit 4 on the step from 1 to 0, and then hold at 0.
- R8: A 1 written to a bit of the event register (0x2C) clears that bit, and a 0 leaves it unchanged.
- R9: Event bits set whatever the mask is. The interrupt output is high exactly while an event bit and the same bit of the mask (0x28) are both 1.
- R10: After reset, every register reads 0, busy and the error flag are low, and the interrupt output is low.
- R11: A read of an offset outside the map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
A slow edge reaches the counters three bus cycles after the slow input rises: two synchronizer flops and one edge-detect flop. The bus-side copy follows one cycle after that. The bench therefore holds the slow input high and then low for four bus cycles each, and samples only after both phases, when every effect of that edge has settled. Read data is combinational and is sampled 1 ns after the read strobe is driven at a falling clock edge. The shadow register and all written registers update on the next rising edge, so each later access sees the new value. Expected values come from the slow-edge count alone: floor(3n/8) millisecond steps, the last multiple of 4 for copies, and the edge index modulo 4 for busy.

// File: rtl/rtc_counter_pkg.sv
package rtc_counter_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int EVT_N  = 5;
    localparam int ALM_N  = 3;
    localparam int CDN_N  = 2;

    localparam logic [ADDR_W-1:0] ADR_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] ADR_MSEC   = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_ALM0   = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_ALM1   = 8'h18;
    localparam logic [ADDR_W-1:0] ADR_MALM   = 8'h1C;
    localparam logic [ADDR_W-1:0] ADR_SCDN   = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_MCDN   = 8'h24;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 8'h2C;

    localparam int ERR_BIT = 1;

    // strobes produced by the slow-clock front end
    typedef struct packed {
        logic msec;   // one millisecond step
        logic copy;   // load bus-side copy from live counters
    } strobe_t;

    function automatic logic [ADDR_W-1:0] alarm_addr(input int idx);
        case (idx)
            0:       return ADR_ALM0;
            1:       return ADR_ALM1;
            default: return ADR_MALM;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cdn_addr(input int idx);
        return (idx == 0) ? ADR_SCDN : ADR_MCDN;
    endfunction

    // alarm fires when the counter takes a new value equal to a non-zero target
    function automatic logic alarm_hit(input logic upd,
                                       input logic [DATA_W-1:0] next_val,
                                       input logic [DATA_W-1:0] target);
        return upd && (target != '0) && (next_val == target);
    endfunction

endpackage

// File: rtl/rtc_strobe_gen.sv
module rtc_strobe_gen
    import rtc_counter_pkg::*;
#(
    parameter int FRAC_INC   = 1000,
    parameter int FRAC_MOD   = 32768,
    parameter int COPY_TICKS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    slow_clk_i,
    output strobe_t strb_o,
    output logic    busy_o
);
    localparam int ACC_W = $clog2(FRAC_MOD + FRAC_INC + 1);
    localparam int PH_W  = (COPY_TICKS > 2) ? $clog2(COPY_TICKS) : 1;

    logic [2:0]       sync_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [PH_W-1:0]  phase_q;
    logic             copy_pend_q;
    logic             slow_edge;
    logic             ms_ovf;
    logic             last_phase;

    always_comb begin
        slow_edge  = sync_q[1] & ~sync_q[2];
        acc_sum    = acc_q + ACC_W'(FRAC_INC);
        ms_ovf     = (acc_sum >= ACC_W'(FRAC_MOD));
        last_phase = (phase_q == PH_W'(COPY_TICKS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '0;
            acc_q       <= '0;
            phase_q     <= '0;
            copy_pend_q <= 1'b0;
        end else begin
            sync_q      <= {sync_q[1:0], slow_clk_i};
            copy_pend_q <= slow_edge & last_phase;
            if (slow_edge) begin
                acc_q   <= ms_ovf ? (acc_sum - ACC_W'(FRAC_MOD)) : acc_sum;
                phase_q <= last_phase ? '0 : phase_q + 1'b1;
            end
        end
    end

    always_comb begin
        strb_o.msec = slow_edge & ms_ovf;
        strb_o.copy = copy_pend_q;
        busy_o      = last_phase | copy_pend_q;
    end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int SEC_W   = 32,
    parameter int MS_WRAP = 1000,
    localparam int MS_W   = $clog2(MS_WRAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_step_i,
    input  logic             sec_load_i,
    input  logic [SEC_W-1:0] sec_wval_i,
    output logic [MS_W-1:0]  ms_q,
    output logic [SEC_W-1:0] sec_q,
    output logic [MS_W-1:0]  ms_next,
    output logic [SEC_W-1:0] sec_next,
    output logic             ms_upd,
    output logic             sec_upd,
    output logic             sec_roll
);
    always_comb begin
        sec_roll = ms_step_i && (ms_q == MS_W'(MS_WRAP - 1));
        if (!ms_step_i)    ms_next = ms_q;
        else if (sec_roll) ms_next = '0;
        else               ms_next = ms_q + 1'b1;
        if (sec_load_i)    sec_next = sec_wval_i;
        else if (sec_roll) sec_next = sec_q + 1'b1;
        else               sec_next = sec_q;
        ms_upd  = ms_step_i;
        sec_upd = sec_load_i | sec_roll;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_q  <= '0;
            sec_q <= '0;
        end else begin
            ms_q  <= ms_next;
            sec_q <= sec_next;
        end
    end

endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (step_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign fire_o = step_i && !load_i && (cnt_q == CNT_W'(1));
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top
    import rtc_counter_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int MS_WRAP    = 1000,
    parameter int FRAC_INC   = 1000,
    parameter int FRAC_MOD   = 32768,
    parameter int COPY_TICKS = 8,
    parameter int CDN_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int MS_W = $clog2(MS_WRAP);

    strobe_t           strb;
    logic              busy;
    logic              wr_ok;
    logic              err_q;

    logic [MS_W-1:0]   ms_live, ms_next;
    logic [SEC_W-1:0]  sec_live, sec_next;
    logic              ms_upd, sec_upd, sec_roll;

    logic [SEC_W-1:0]  sec_bus_q;
    logic [MS_W-1:0]   ms_bus_q;
    logic [SEC_W-1:0]  shadow_q;

    logic [DATA_W-1:0] alm_q [ALM_N];
    logic [ALM_N-1:0]  alm_fire;
    logic [CDN_W-1:0]  cdn_cnt [CDN_N];
    logic [CDN_N-1:0]  cdn_fire;
    logic [EVT_N-1:0]  evt_set, evt_clr;
    logic [EVT_N-1:0]  mask_q, status_q;

    logic [DATA_W-1:0] sec_bus_w, shadow_w, ms_live_w;

    rtc_strobe_gen #(
        .FRAC_INC  (FRAC_INC),
        .FRAC_MOD  (FRAC_MOD),
        .COPY_TICKS(COPY_TICKS)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .slow_clk_i(slow_clk_i),
        .strb_o    (strb),
        .busy_o    (busy)
    );

    assign wr_ok = bus_wr_i & ~busy;

    rtc_timebase #(
        .SEC_W  (SEC_W),
        .MS_WRAP(MS_WRAP)
    ) u_time (
        .clk       (clk),
        .rst       (rst),
        .ms_step_i (strb.msec),
        .sec_load_i(wr_ok && bus_addr_i == ADR_SEC),
        .sec_wval_i(bus_wdata_i[SEC_W-1:0]),
        .ms_q      (ms_live),
        .sec_q     (sec_live),
        .ms_next   (ms_next),
        .sec_next  (sec_next),
        .ms_upd    (ms_upd),
        .sec_upd   (sec_upd),
        .sec_roll  (sec_roll)
    );

    // alarm comparators: two on seconds, one on milliseconds
    for (genvar a = 0; a < ALM_N; a++) begin : g_alarm
        logic [DATA_W-1:0] cur;
        logic              upd;
        if (a < 2) begin : g_sec
            assign cur = DATA_W'(sec_next);
            assign upd = sec_upd;
        end else begin : g_ms
            assign cur = DATA_W'(ms_next);
            assign upd = ms_upd;
        end
        assign alm_fire[a] = alarm_hit(upd, cur, alm_q[a]);
    end

    // countdowns: index 0 steps on seconds rollover, index 1 on milliseconds
    for (genvar c = 0; c < CDN_N; c++) begin : g_cdn
        logic step;
        if (c == 0) begin : g_s
            assign step = sec_roll;
        end else begin : g_m
            assign step = strb.msec;
        end
        rtc_countdown #(.CNT_W(CDN_W)) u_cdn (
            .clk       (clk),
            .rst       (rst),
            .load_i    (wr_ok && bus_addr_i == cdn_addr(c)),
            .load_val_i(bus_wdata_i[CDN_W-1:0]),
            .step_i    (step),
            .cnt_o     (cdn_cnt[c]),
            .fire_o    (cdn_fire[c])
        );
    end

    always_comb begin
        evt_set = {cdn_fire, alm_fire};
        evt_clr = (wr_ok && bus_addr_i == ADR_STAT) ? bus_wdata_i[EVT_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_bus_q <= '0;
            ms_bus_q  <= '0;
            shadow_q  <= '0;
            err_q     <= 1'b0;
            mask_q    <= '0;
            status_q  <= '0;
            for (int a = 0; a < ALM_N; a++) alm_q[a] <= '0;
        end else begin
            if (strb.copy) begin
                sec_bus_q <= sec_live;
                ms_bus_q  <= ms_live;
            end else if (wr_ok && bus_addr_i == ADR_SEC) begin
                sec_bus_q <= bus_wdata_i[SEC_W-1:0];
            end
            if (bus_rd_i && bus_addr_i == ADR_MSEC) shadow_q <= sec_bus_q;
            if (bus_wr_i && busy)
                err_q <= 1'b1;
            else if (wr_ok && bus_addr_i == ADR_BUSY && bus_wdata_i[ERR_BIT])
                err_q <= 1'b0;
            if (wr_ok && bus_addr_i == ADR_MASK) mask_q <= bus_wdata_i[EVT_N-1:0];
            for (int a = 0; a < ALM_N; a++)
                if (wr_ok && bus_addr_i == alarm_addr(a)) alm_q[a] <= bus_wdata_i;
            // a new event wins over a clear in the same cycle
            status_q <= (status_q & ~evt_clr) | evt_set;
        end
    end

    always_comb begin
        sec_bus_w = DATA_W'(sec_bus_q);
        shadow_w  = DATA_W'(shadow_q);
        ms_live_w = DATA_W'(ms_live);
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (bus_addr_i)
                ADR_BUSY:   bus_rdata_o[1:0] = {err_q, busy};
                ADR_SEC:    bus_rdata_o = sec_bus_w;
                ADR_SHADOW: bus_rdata_o = shadow_w;
                ADR_MSEC:   bus_rdata_o = DATA_W'(ms_bus_q);
                ADR_ALM0:   bus_rdata_o = alm_q[0];
                ADR_ALM1:   bus_rdata_o = alm_q[1];
                ADR_MALM:   bus_rdata_o = alm_q[2];
                ADR_SCDN:   bus_rdata_o = DATA_W'(cdn_cnt[0]);
                ADR_MCDN:   bus_rdata_o = DATA_W'(cdn_cnt[1]);
                ADR_MASK:   bus_rdata_o[EVT_N-1:0] = mask_q;
                ADR_STAT:   bus_rdata_o[EVT_N-1:0] = status_q;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o = |(status_q & mask_q);

endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk
    import rtc_counter_pkg::*;
#(
    parameter int MS_WRAP = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic              busy,
    input logic              err_q,
    input logic [DATA_W-1:0] sec_bus_w,
    input logic [DATA_W-1:0] shadow_w,
    input logic [DATA_W-1:0] ms_live_w,
    input logic [EVT_N-1:0]  status_q,
    input logic [EVT_N-1:0]  mask_q,
    input logic              irq_o
);
    // R1: live milliseconds stay inside their wrap range
    a_r1_ms_in_range: assert property (@(posedge clk) disable iff (rst)
        ms_live_w < DATA_W'(MS_WRAP));

    // R2: a milliseconds read captures the bus-side seconds into the shadow
    a_r2_shadow_latch: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == ADR_MSEC) |=> (shadow_w == $past(sec_bus_w)));

    // R4: a write attempted in the busy window leaves the error flag set
    a_r4_drop_flags_error: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && busy) |=> err_q);

    // R8: an event bit only falls after an accepted write to the event register
    a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
        (|($past(status_q) & ~status_q)) |->
            $past(bus_wr_i && !busy && bus_addr_i == ADR_STAT));

    // R9: no interrupt without an enabled and pending event
    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|mask_q && |status_q));

endmodule

bind rtc_counter_top rtc_counter_chk #(.MS_WRAP(MS_WRAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr_i(bus_addr_i),
    .bus_wr_i  (bus_wr_i),
    .bus_rd_i  (bus_rd_i),
    .busy      (busy),
    .err_q     (err_q),
    .sec_bus_w (sec_bus_w),
    .shadow_w  (shadow_w),
    .ms_live_w (ms_live_w),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq_o     (irq_o)
);

// File: tb/tb_rtc_counter_top.sv
`timescale 1ns/1ps
module tb_rtc_counter_top;
    localparam int P_INC  = 3;
    localparam int P_MOD  = 8;
    localparam int P_WRAP = 5;
    localparam int P_COPY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #10 clk = ~clk;

    rtc_counter_top #(
        .SEC_W(32), .MS_WRAP(P_WRAP), .FRAC_INC(P_INC), .FRAC_MOD(P_MOD),
        .COPY_TICKS(P_COPY), .CDN_W(8)
    ) dut (
        .clk(clk), .rst(rst), .slow_clk_i(slow), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    int errors = 0;
    int checks = 0;
    int n = 0;          // slow edges since reset
    int sec_base = 0;   // last seconds value written
    int nw = 0;         // edge count at that write
    logic [31:0] d;

    function automatic int mstot(input int k);
        return (k * P_INC) / P_MOD;
    endfunction

    function automatic int live_sec(input int k);
        return sec_base + mstot(k) / P_WRAP - mstot(nw) / P_WRAP;
    endfunction

    function automatic int bus_sec();
        int nc;
        nc = (n / P_COPY) * P_COPY;
        return (nc > nw) ? live_sec(nc) : sec_base;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        slow = 1'b1;
        repeat (4) @(negedge clk);
        slow = 1'b0;
        repeat (4) @(negedge clk);
        n++;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic free();
        while (n % P_COPY == P_COPY - 1) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int a0, ls, prev, m, seen, after, n0, r, dm;
        logic [7:0] regs [11];
        regs = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        foreach (regs[i]) begin
            rd_reg(regs[i], d);
            check("R10 reset register", d, 32'd0);
        end
        check("R10 reset irq", {31'd0, irq}, 32'd0);

        // R11: unmapped offset
        rd_reg(8'h30, d);
        check("R11 unmapped read", d, 32'd0);

        // sweep of slow edges: divider, copy, busy, shadow
        for (int k = 0; k < 48; k++) begin
            tick();
            rd_reg(8'h10, d);
            check("R1/R3 msec copy", d, mstot((n / P_COPY) * P_COPY) % P_WRAP);
            rd_reg(8'h0C, d);
            check("R2 shadow", d, bus_sec());
            rd_reg(8'h04, d);
            check("R3 busy", d, (n % P_COPY == P_COPY - 1) ? 32'd1 : 32'd0);
            rd_reg(8'h08, d);
            check("R3 seconds copy", d, bus_sec());
        end

        // R4: write in the busy window is dropped
        while (n % P_COPY != P_COPY - 1) tick();
        wr_reg(8'h08, 32'd100);
        rd_reg(8'h04, d);
        check("R4 error flag", d, 32'd3);
        rd_reg(8'h08, d);
        check("R4 dropped write", d, bus_sec());
        tick();
        wr_reg(8'h04, 32'd2);
        rd_reg(8'h04, d);
        check("R4 error clear", d, 32'd0);

        // R5: seconds load
        free();
        wr_reg(8'h08, 32'd100);
        sec_base = 100; nw = n;
        rd_reg(8'h08, d);
        check("R5 seconds load", d, 32'd100);
        for (int k = 0; k < 8; k++) begin
            tick();
            rd_reg(8'h08, d);
            check("R5 count from load", d, bus_sec());
        end

        // R6/R9: seconds alarms, only alarm 0 enabled in the mask
        free();
        a0 = live_sec(n) + 1;
        wr_reg(8'h14, a0);
        wr_reg(8'h18, a0 + 1);
        wr_reg(8'h28, 32'd1);
        for (int k = 0; k < 80; k++) begin
            tick();
            ls = live_sec(n);
            rd_reg(8'h2C, d);
            check("R6 seconds alarms", d, ((ls >= a0) ? 1 : 0) + ((ls >= a0 + 1) ? 2 : 0));
            check("R9 irq masked", {31'd0, irq}, (ls >= a0) ? 32'd1 : 32'd0);
            if (ls >= a0 + 1) break;
        end

        // R8/R9: write-one-to-clear and mask
        free(); wr_reg(8'h2C, 32'd1);
        rd_reg(8'h2C, d);
        check("R8 clear bit 0", d, 32'd2);
        check("R9 irq off", {31'd0, irq}, 32'd0);
        free(); wr_reg(8'h28, 32'd2);
        check("R9 irq from bit 1", {31'd0, irq}, 32'd1);
        free(); wr_reg(8'h2C, 32'd0);
        rd_reg(8'h2C, d);
        check("R8 zero write", d, 32'd2);
        free(); wr_reg(8'h2C, 32'h1F);
        rd_reg(8'h2C, d);
        check("R8 clear all", d, 32'd0);
        check("R9 irq after clear", {31'd0, irq}, 32'd0);

        // R6: milliseconds alarm at value 3
        free(); wr_reg(8'h1C, 32'd3);
        prev = mstot(n); seen = 0; after = 0;
        for (int k = 0; k < 60; k++) begin
            tick();
            m = mstot(n);
            if (m != prev && m % P_WRAP == 3) seen = 1;
            prev = m;
            rd_reg(8'h2C, d);
            check("R6 msec alarm", d, seen ? 32'd4 : 32'd0);
            if (seen != 0) after++;
            if (after == 3) break;
        end

        // R6: zero alarm value never fires
        free(); wr_reg(8'h1C, 32'd0);
        free(); wr_reg(8'h14, 32'd0);
        free(); wr_reg(8'h18, 32'd0);
        free(); wr_reg(8'h2C, 32'h1F);
        free(); wr_reg(8'h08, 32'd0);
        sec_base = 0; nw = n;
        rd_reg(8'h2C, d);
        check("R6 zero alarm disabled", d, 32'd0);
        rd_reg(8'h08, d);
        check("R5 load zero", d, 32'd0);

        // R7: countdowns
        free();
        wr_reg(8'h20, 32'd2);
        wr_reg(8'h24, 32'd4);
        n0 = n;
        for (int k = 0; k < 40; k++) begin
            tick();
            r  = mstot(n) / P_WRAP - mstot(n0) / P_WRAP;
            dm = mstot(n) - mstot(n0);
            rd_reg(8'h20, d);
            check("R7 seconds countdown", d, (r >= 2) ? 0 : 2 - r);
            rd_reg(8'h24, d);
            check("R7 msec countdown", d, (dm >= 4) ? 0 : 4 - dm);
            rd_reg(8'h2C, d);
            check("R7 countdown events", d, ((r >= 2) ? 8 : 0) + ((dm >= 4) ? 16 : 0));
        end
        free(); wr_reg(8'h28, 32'd8);
        check("R9 irq from countdown", {31'd0, irq}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule